// File: doc/BRIEF.md
# Page-Granular Snooping Coherence Cluster

This block keeps a group of accelerator-local page stores coherent with one another. Each accelerator has its own controller. The controller keeps a small table of page slots, and each slot holds a virtual page number and a two-bit coherence state. Software fills the table whenever it places a page in an accelerator's local store. For example, software marks a page shared when the same page already lives in another accelerator. The accelerator then presents each access as a virtual page number with a read/write flag. The controller answers with a combinational miss, which tells software to fetch the page, or with a stall.

A write to a page held shared has to become exclusive first. The controller requests a dedicated coherence bus, which is separate from the system bus. A round-robin arbiter grants the bus one unit at a time, and software can mask individual units out of arbitration. In the grant cycle the winning unit broadcasts an invalidation carrying the page number for one cycle. Its own copy then turns modified. Every other unit snoops the broadcast. A shared copy becomes invalid. A modified copy is kept and a coherence fault is raised for software, so that data is never dropped silently. Slots holding modified pages are reported on a dirty vector, so that software writes them back before reusing the slot.

Each controller has two states. F_IDLE serves accesses. F_REQ holds a pending upgrade while the unit waits for the bus. There are three transitions. The start-upgrade transition goes from F_IDLE to F_REQ on a write that hits a shared page. The granted transition goes from F_REQ to F_IDLE when the bus is granted, and the page becomes modified on that edge. The aborted transition goes from F_REQ to F_IDLE when the pending page is invalidated by a snoop, or rewritten by software, before the grant arrives.

Top module: `pgcoh_cluster`

## Requirements
- R1: After reset every slot is INVALID, so every access misses. No dirty bit, no fault, no stall and no bus activity is present.
- R2: A software write stores a page number and a state into the selected slot of the selected unit. The state encoding is 00 INVALID, 01 SHARED, 10 MODIFIED, and 11 is stored as INVALID. Bit unit*N_PAGES+slot of `pg_dirty` is high exactly while that slot is MODIFIED.
- R3: An access hits when its page number matches a slot that is not INVALID; otherwise `acc_miss` is high in the same cycle. Reads and writes to MODIFIED pages never stall.
- R4: A write hitting a SHARED page stalls in the same cycle. The unit requests the bus from the next cycle and stays stalled through the grant cycle. From the cycle after the grant the page is MODIFIED and the stall is released.
- R5: A broadcast from another unit whose page number matches a SHARED slot makes that slot INVALID from the next cycle. A unit ignores its own broadcast.
- R6: A broadcast matching a MODIFIED slot in another unit leaves that slot MODIFIED and sets `coh_fault` of that unit from the next cycle. The fault holds until software writes any slot of that unit.
- R7: If a pending upgrade's page is invalidated before the grant, the unit leaves the wait state without broadcasting, and the access then misses.
- R8: At most one unit is granted per cycle. The grant goes to the first requesting, unmasked unit at or after a rotating pointer. After a grant the pointer moves to one past the granted unit, and the pointer is 0 after reset.
- R9: A unit whose `arb_mask` bit is 0 is never granted and stays stalled. Setting the bit lets it be granted in the same cycle.
- R10: Each upgrade produces exactly one bus cycle. `bus_valid` is high only in grant cycles, and `bus_src` and `bus_vpn` name the granted unit and its page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | N_UNITS | Per-unit access valid |
| acc_we | input | N_UNITS | Per-unit access is a write |
| acc_vpn | input | N_UNITS*VPN_W | Per-unit access page number, unit u in slice u |
| acc_stall | output | N_UNITS | Per-unit stall |
| acc_miss | output | N_UNITS | Per-unit page miss |
| sw_wr | input | 1 | Software slot write strobe |
| sw_unit | input | UNIT_W | Target unit of the slot write |
| sw_slot | input | SLOT_W | Target slot of the slot write |
| sw_vpn | input | VPN_W | Page number written |
| sw_state | input | 2 | State written (00/01/10, 11 as 00) |
| arb_mask | input | N_UNITS | Per-unit arbitration enable |
| pg_dirty | output | N_UNITS*N_PAGES | MODIFIED flag per slot |
| coh_fault | output | N_UNITS | Sticky snoop-hit-on-modified fault |
| bus_valid | output | 1 | Invalidation broadcast this cycle |
| bus_src | output | UNIT_W | Broadcasting unit |
| bus_vpn | output | VPN_W | Broadcast page number |

## Verification
The slot table is swept over every unit, slot and state code, including the unused code 11. Each entry is probed with a read, or with a write on MODIFIED pages, which separates the hit, miss and dirty decoding of each encoding. Upgrades are run in four settings: alone, against shared copies elsewhere (R5), against a remote modified copy (R6), and with all three units contending. The contending case is repeated from two pointer positions, and the grant order is computed from the rotation rule, so a fixed-priority arbiter is told apart from a rotating one. Masking is tried both as a permanent block that ends in an abort, which exposes a missing abort path or a stray broadcast, and as a block that is lifted, which exposes a grant that is not combinational.

// File: rtl/pgcoh_pkg.sv
package pgcoh_pkg;

    typedef enum logic [1:0] {
        PG_INVALID  = 2'b00,
        PG_SHARED   = 2'b01,
        PG_MODIFIED = 2'b10
    } pg_state_t;

    typedef enum logic {
        F_IDLE = 1'b0,
        F_REQ  = 1'b1
    } upg_fsm_t;

    function automatic pg_state_t decode_state(input logic [1:0] code);
        unique case (code)
            2'b01:   decode_state = PG_SHARED;
            2'b10:   decode_state = PG_MODIFIED;
            default: decode_state = PG_INVALID;
        endcase
    endfunction

endpackage

// File: rtl/pgcoh_rr_arb.sv
module pgcoh_rr_arb #(
    parameter int N_UNITS = 3,
    parameter int UNIT_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_UNITS-1:0] req,
    input  logic [N_UNITS-1:0] mask,
    output logic [N_UNITS-1:0] gnt,
    output logic [UNIT_W-1:0]  gnt_idx
);

    logic [UNIT_W-1:0] ptr_q;
    logic              found;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < N_UNITS; k++) begin
            int cand;
            cand = int'(ptr_q) + k;
            if (cand >= N_UNITS) cand = cand - N_UNITS;
            if (!found && req[cand] && mask[cand]) begin
                gnt[cand] = 1'b1;
                gnt_idx   = UNIT_W'(cand);
                found     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (found) begin
            if (int'(gnt_idx) == N_UNITS - 1) ptr_q <= '0;
            else                              ptr_q <= gnt_idx + UNIT_W'(1);
        end
    end

    // R8: never more than one grant per cycle
    a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R9: a grant only reaches a unit that requests and is enabled
    a_r9_grant_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~(req & mask)) == '0);

endmodule

// File: rtl/pgcoh_unit.sv
module pgcoh_unit
    import pgcoh_pkg::*;
#(
    parameter int N_UNITS = 3,
    parameter int N_PAGES = 4,
    parameter int VPN_W   = 8,
    parameter int UNIT_ID = 0,
    parameter int UNIT_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
    parameter int SLOT_W  = (N_PAGES > 1) ? $clog2(N_PAGES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_req,
    input  logic               acc_we,
    input  logic [VPN_W-1:0]   acc_vpn,
    output logic               acc_stall,
    output logic               acc_miss,
    input  logic               sw_wr,
    input  logic [SLOT_W-1:0]  sw_slot,
    input  logic [VPN_W-1:0]   sw_vpn,
    input  logic [1:0]         sw_state,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [VPN_W-1:0]   up_vpn,
    input  logic               snp_valid,
    input  logic [UNIT_W-1:0]  snp_src,
    input  logic [VPN_W-1:0]   snp_vpn,
    output logic [N_PAGES-1:0] dirty_o,
    output logic               fault_o
);

    pg_state_t          st_a  [N_PAGES];
    logic [VPN_W-1:0]   tag_a [N_PAGES];
    logic [N_PAGES-1:0] hit_v;
    logic [N_PAGES-1:0] snp_hit;
    logic [N_PAGES-1:0] snp_mod_hit;
    logic               any_hit;
    logic [SLOT_W-1:0]  hit_slot;
    logic               need_up;
    logic               remote_snp;
    logic               sw_on_pending;
    upg_fsm_t           fsm_q, fsm_d;
    logic [SLOT_W-1:0]  slot_q;
    logic [VPN_W-1:0]   vpn_q;

    assign remote_snp = snp_valid && (snp_src != UNIT_W'(UNIT_ID));

    for (genvar s = 0; s < N_PAGES; s++) begin : g_slot
        pg_state_t        st_q;
        logic [VPN_W-1:0] tag_q;
        logic             sw_here;

        assign sw_here = sw_wr && (sw_slot == SLOT_W'(s));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= PG_INVALID;
                tag_q <= '0;
            end else if (sw_here) begin
                st_q  <= decode_state(sw_state);
                tag_q <= sw_vpn;
            end else if (snp_hit[s]) begin
                if (st_q == PG_SHARED) st_q <= PG_INVALID;
            end else if (fsm_q == F_REQ && bus_gnt && slot_q == SLOT_W'(s)) begin
                st_q <= PG_MODIFIED;
            end
        end

        assign st_a[s]        = st_q;
        assign tag_a[s]       = tag_q;
        assign hit_v[s]       = (st_q != PG_INVALID) && (tag_q == acc_vpn);
        assign snp_hit[s]     = remote_snp && (st_q != PG_INVALID) && (tag_q == snp_vpn);
        assign snp_mod_hit[s] = snp_hit[s] && (st_q == PG_MODIFIED);
        assign dirty_o[s]     = (st_q == PG_MODIFIED);

        // R5: a remote broadcast drops a shared copy on the next edge
        a_r5_shared_dropped: assert property (@(posedge clk) disable iff (!rst_n)
            (snp_hit[s] && st_q == PG_SHARED && !sw_here) |=> (st_q == PG_INVALID));
    end

    always_comb begin
        any_hit  = 1'b0;
        hit_slot = '0;
        for (int s = N_PAGES - 1; s >= 0; s--) begin
            if (hit_v[s]) begin
                any_hit  = 1'b1;
                hit_slot = SLOT_W'(s);
            end
        end
    end

    assign need_up       = acc_req && acc_we && any_hit && (st_a[hit_slot] == PG_SHARED);
    assign sw_on_pending = sw_wr && (sw_slot == slot_q);

    // next-state logic
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            F_IDLE: if (need_up) fsm_d = F_REQ;
            F_REQ: begin
                if (bus_gnt)                                fsm_d = F_IDLE;
                else if (snp_hit[slot_q] || sw_on_pending)  fsm_d = F_IDLE;
            end
            default: fsm_d = F_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q  <= F_IDLE;
            slot_q <= '0;
            vpn_q  <= '0;
        end else begin
            fsm_q <= fsm_d;
            if (fsm_q == F_IDLE && need_up) begin
                slot_q <= hit_slot;
                vpn_q  <= acc_vpn;
            end
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        acc_stall = 1'b0;
        acc_miss  = 1'b0;
        unique case (fsm_q)
            F_IDLE: begin
                acc_stall = need_up;
                acc_miss  = acc_req && !any_hit;
            end
            F_REQ: begin
                bus_req   = 1'b1;
                acc_stall = 1'b1;
            end
            default: ;
        endcase
    end

    assign up_vpn = vpn_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            fault_o <= 1'b0;
        else if (sw_wr)        fault_o <= 1'b0;
        else if (|snp_mod_hit) fault_o <= 1'b1;
    end

    // R4: waiting for the bus always stalls the accelerator
    a_r4_wait_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == F_REQ) |-> acc_stall);

    // R4: a granted upgrade leaves the page modified
    a_r4_grant_modifies: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == F_REQ && bus_gnt && !sw_on_pending) |=> dirty_o[slot_q]);

    // R6: a snoop hitting a modified page raises the fault
    a_r6_fault_raised: assert property (@(posedge clk) disable iff (!rst_n)
        ((|snp_mod_hit) && !sw_wr) |=> fault_o);

endmodule

// File: rtl/pgcoh_cluster.sv
module pgcoh_cluster #(
    parameter int N_UNITS = 3,
    parameter int N_PAGES = 4,
    parameter int VPN_W   = 8,
    localparam int UNIT_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
    localparam int SLOT_W = (N_PAGES > 1) ? $clog2(N_PAGES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_UNITS-1:0]         acc_req,
    input  logic [N_UNITS-1:0]         acc_we,
    input  logic [N_UNITS*VPN_W-1:0]   acc_vpn,
    output logic [N_UNITS-1:0]         acc_stall,
    output logic [N_UNITS-1:0]         acc_miss,
    input  logic                       sw_wr,
    input  logic [UNIT_W-1:0]          sw_unit,
    input  logic [SLOT_W-1:0]          sw_slot,
    input  logic [VPN_W-1:0]           sw_vpn,
    input  logic [1:0]                 sw_state,
    input  logic [N_UNITS-1:0]         arb_mask,
    output logic [N_UNITS*N_PAGES-1:0] pg_dirty,
    output logic [N_UNITS-1:0]         coh_fault,
    output logic                       bus_valid,
    output logic [UNIT_W-1:0]          bus_src,
    output logic [VPN_W-1:0]           bus_vpn
);

    logic [N_UNITS-1:0] bus_req;
    logic [N_UNITS-1:0] gnt;
    logic [UNIT_W-1:0]  gnt_idx;
    logic [VPN_W-1:0]   up_vpn [N_UNITS];

    pgcoh_rr_arb #(
        .N_UNITS (N_UNITS),
        .UNIT_W  (UNIT_W)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .mask    (arb_mask),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        pgcoh_unit #(
            .N_UNITS (N_UNITS),
            .N_PAGES (N_PAGES),
            .VPN_W   (VPN_W),
            .UNIT_ID (u),
            .UNIT_W  (UNIT_W),
            .SLOT_W  (SLOT_W)
        ) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_req   (acc_req[u]),
            .acc_we    (acc_we[u]),
            .acc_vpn   (acc_vpn[u*VPN_W +: VPN_W]),
            .acc_stall (acc_stall[u]),
            .acc_miss  (acc_miss[u]),
            .sw_wr     (sw_wr && (sw_unit == UNIT_W'(u))),
            .sw_slot   (sw_slot),
            .sw_vpn    (sw_vpn),
            .sw_state  (sw_state),
            .bus_req   (bus_req[u]),
            .bus_gnt   (gnt[u]),
            .up_vpn    (up_vpn[u]),
            .snp_valid (bus_valid),
            .snp_src   (bus_src),
            .snp_vpn   (bus_vpn),
            .dirty_o   (pg_dirty[u*N_PAGES +: N_PAGES]),
            .fault_o   (coh_fault[u])
        );
    end

    always_comb begin
        bus_vpn = '0;
        for (int u = 0; u < N_UNITS; u++) begin
            if (gnt[u]) bus_vpn = bus_vpn | up_vpn[u];
        end
    end

    assign bus_valid = |gnt;
    assign bus_src   = gnt_idx;

    // R10: one broadcast per upgrade, never two back-to-back from one unit
    a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> !(bus_valid && bus_src == $past(bus_src)));

    // R9: a masked unit never broadcasts
    a_r9_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> arb_mask[bus_src]);

endmodule

// File: tb/pgcoh_cluster_bench.sv
`timescale 1ns/1ps
module pgcoh_cluster_bench;

    localparam int NU = 3;
    localparam int NP = 4;
    localparam int VW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NU-1:0]   acc_req = '0;
    logic [NU-1:0]   acc_we = '0;
    logic [NU*VW-1:0] acc_vpn = '0;
    logic [NU-1:0]   acc_stall;
    logic [NU-1:0]   acc_miss;
    logic            sw_wr = 1'b0;
    logic [1:0]      sw_unit = '0;
    logic [1:0]      sw_slot = '0;
    logic [VW-1:0]   sw_vpn = '0;
    logic [1:0]      sw_state = '0;
    logic [NU-1:0]   arb_mask = '1;
    logic [NU*NP-1:0] pg_dirty;
    logic [NU-1:0]   coh_fault;
    logic            bus_valid;
    logic [1:0]      bus_src;
    logic [VW-1:0]   bus_vpn;

    int n_chk = 0;
    int n_fail = 0;
    int rr_ptr = 0;

    always #10 clk = ~clk;

    pgcoh_cluster #(.N_UNITS(NU), .N_PAGES(NP), .VPN_W(VW)) u_pgcoh_cluster (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
        .acc_vpn(acc_vpn), .acc_stall(acc_stall), .acc_miss(acc_miss),
        .sw_wr(sw_wr), .sw_unit(sw_unit), .sw_slot(sw_slot), .sw_vpn(sw_vpn),
        .sw_state(sw_state), .arb_mask(arb_mask), .pg_dirty(pg_dirty),
        .coh_fault(coh_fault), .bus_valid(bus_valid), .bus_src(bus_src),
        .bus_vpn(bus_vpn)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic smp();
        @(negedge clk);
    endtask

    task automatic set_acc(input int u, input logic rq, input logic we, input logic [VW-1:0] v);
        acc_req[u] = rq;
        acc_we[u]  = we;
        acc_vpn[u*VW +: VW] = v;
    endtask

    task automatic sw_write(input int u, input int s, input logic [VW-1:0] v, input logic [1:0] st);
        sw_wr = 1'b1; sw_unit = 2'(u); sw_slot = 2'(s); sw_vpn = v; sw_state = st;
        tick();
        sw_wr = 1'b0;
    endtask

    task automatic clear_all();
        for (int u = 0; u < NU; u++)
            for (int s = 0; s < NP; s++)
                sw_write(u, s, 8'h00, 2'b00);
    endtask

    // write upgrade by a single unit on a shared page; checks R4/R10 timing
    task automatic solo_upgrade(input int u, input int s, input logic [VW-1:0] v);
        set_acc(u, 1'b1, 1'b1, v);
        smp();
        chk("R4 stall on shared write", 32'(acc_stall[u]), 32'd1);
        chk("R4 no bus before request", 32'(bus_valid), 32'd0);
        tick(); smp();
        chk("R10 bus valid in grant", 32'(bus_valid), 32'd1);
        chk("R10 bus src", 32'(bus_src), 32'(u));
        chk("R10 bus vpn", 32'(bus_vpn), 32'(v));
        chk("R4 stalled in grant cycle", 32'(acc_stall[u]), 32'd1);
        rr_ptr = (u + 1) % NU;
        tick(); smp();
        chk("R4 stall released", 32'(acc_stall[u]), 32'd0);
        chk("R10 bus idle after grant", 32'(bus_valid), 32'd0);
        chk("R4 page modified", 32'(pg_dirty[u*NP+s]), 32'd1);
        set_acc(u, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic rr_round();
        logic [NU-1:0] pend;
        clear_all();
        for (int u = 0; u < NU; u++) sw_write(u, 0, 8'(8'h60 + u), 2'b01);
        for (int u = 0; u < NU; u++) set_acc(u, 1'b1, 1'b1, 8'(8'h60 + u));
        smp();
        chk("R4 all stalled", 32'(acc_stall), 32'(3'b111));
        pend = '1;
        for (int k = 0; k < NU; k++) begin
            int g;
            g = -1;
            for (int j = 0; j < NU; j++) begin
                int c;
                c = (rr_ptr + j) % NU;
                if (g < 0 && pend[c]) g = c;
            end
            tick(); smp();
            chk("R8 grant present", 32'(bus_valid), 32'd1);
            chk("R8 rotating order", 32'(bus_src), 32'(g));
            chk("R10 vpn of granted unit", 32'(bus_vpn), 32'(8'h60 + g));
            chk("R4 waiting units stalled", 32'(acc_stall), 32'(pend));
            pend[g] = 1'b0;
            rr_ptr = (g + 1) % NU;
        end
        tick(); smp();
        chk("R8 all served", 32'(acc_stall), 32'd0);
        chk("R10 bus idle", 32'(bus_valid), 32'd0);
        chk("R4 all modified", 32'({pg_dirty[8], pg_dirty[4], pg_dirty[0]}), 32'(3'b111));
        for (int u = 0; u < NU; u++) set_acc(u, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        for (int u = 0; u < NU; u++) set_acc(u, 1'b1, 1'b0, 8'h00);
        smp();
        chk("R1 dirty clear", 32'(pg_dirty), 32'd0);
        chk("R1 fault clear", 32'(coh_fault), 32'd0);
        chk("R1 no stall", 32'(acc_stall), 32'd0);
        chk("R1 bus idle", 32'(bus_valid), 32'd0);
        chk("R1 all miss", 32'(acc_miss), 32'(3'b111));
        for (int u = 0; u < NU; u++) set_acc(u, 1'b0, 1'b0, 8'h00);

        // R2/R3 sweep over units, slots and state codes
        for (int u = 0; u < NU; u++)
            for (int s = 0; s < NP; s++)
                for (int st = 0; st < 4; st++) begin
                    logic [VW-1:0] v;
                    logic [NU*NP-1:0] expd;
                    v = 8'(8'h80 + u * 16 + s * 4 + st);
                    sw_write(u, s, v, 2'(st));
                    set_acc(u, 1'b1, (st == 2), v);
                    smp();
                    expd = '0;
                    if (st == 2) expd[u*NP+s] = 1'b1;
                    chk("R2 dirty vector", 32'(pg_dirty), 32'(expd));
                    chk("R3 hit or miss", 32'(acc_miss[u]), (st == 1 || st == 2) ? 32'd0 : 32'd1);
                    chk("R3 no stall", 32'(acc_stall[u]), 32'd0);
                    chk("R3 no broadcast", 32'(bus_valid), 32'd0);
                    set_acc(u, 1'b0, 1'b0, 8'h00);
                end

        // R4/R5: upgrade against shared copies elsewhere
        clear_all();
        sw_write(0, 1, 8'h40, 2'b01);
        sw_write(1, 2, 8'h40, 2'b01);
        sw_write(2, 0, 8'h40, 2'b01);
        solo_upgrade(0, 1, 8'h40);
        for (int u = 0; u < NU; u++) set_acc(u, 1'b1, 1'b0, 8'h40);
        smp();
        chk("R5 remote copies invalid", 32'(acc_miss), 32'(3'b110));
        chk("R5 own copy kept", 32'(pg_dirty[1]), 32'd1);
        chk("R5 no fault", 32'(coh_fault), 32'd0);
        for (int u = 0; u < NU; u++) set_acc(u, 1'b0, 1'b0, 8'h00);

        // R6: snoop hits a modified page
        sw_write(1, 3, 8'h55, 2'b10);
        sw_write(2, 1, 8'h55, 2'b01);
        solo_upgrade(2, 1, 8'h55);
        chk("R6 fault raised", 32'(coh_fault), 32'(3'b010));
        chk("R6 modified kept", 32'(pg_dirty[7]), 32'd1);
        tick(); tick(); smp();
        chk("R6 fault sticky", 32'(coh_fault), 32'(3'b010));
        sw_write(1, 0, 8'h00, 2'b00);
        smp();
        chk("R6 fault cleared by write", 32'(coh_fault), 32'd0);

        // R8: contention from two pointer positions
        rr_round();
        clear_all();
        sw_write(1, 2, 8'h6A, 2'b01);
        solo_upgrade(1, 2, 8'h6A);
        rr_round();

        // R9/R7: masked waiter gets aborted by another unit's upgrade
        clear_all();
        sw_write(0, 0, 8'h70, 2'b01);
        sw_write(1, 0, 8'h70, 2'b01);
        arb_mask = 3'b101;
        set_acc(1, 1'b1, 1'b1, 8'h70);
        smp();
        chk("R9 masked unit stalls", 32'(acc_stall[1]), 32'd1);
        for (int k = 0; k < 3; k++) begin
            tick(); smp();
            chk("R9 masked unit not granted", 32'(bus_valid), 32'd0);
            chk("R9 masked unit still stalled", 32'(acc_stall[1]), 32'd1);
        end
        set_acc(0, 1'b1, 1'b1, 8'h70);
        tick(); smp();
        chk("R9 unmasked unit granted", 32'(bus_valid), 32'd1);
        chk("R9 granted source", 32'(bus_src), 32'd0);
        rr_ptr = 1;
        tick(); smp();
        chk("R7 aborted waiter released", 32'(acc_stall[1]), 32'd0);
        chk("R7 aborted access misses", 32'(acc_miss[1]), 32'd1);
        set_acc(0, 1'b0, 1'b0, 8'h00);
        arb_mask = 3'b111;
        for (int k = 0; k < 2; k++) begin
            tick(); smp();
            chk("R7 no broadcast after abort", 32'(bus_valid), 32'd0);
        end
        set_acc(1, 1'b0, 1'b0, 8'h00);

        // R9: lifting the mask grants in the same cycle
        sw_write(2, 1, 8'h71, 2'b01);
        arb_mask = 3'b011;
        set_acc(2, 1'b1, 1'b1, 8'h71);
        tick(); tick(); smp();
        chk("R9 blocked while masked", 32'(bus_valid), 32'd0);
        chk("R9 stalled while masked", 32'(acc_stall[2]), 32'd1);
        arb_mask = 3'b111;
        #1;
        chk("R9 grant once unmasked", 32'(bus_valid), 32'd1);
        chk("R9 grant source unmasked", 32'(bus_src), 32'd2);
        tick(); smp();
        chk("R9 stall released", 32'(acc_stall[2]), 32'd0);
        chk("R9 page modified", 32'(pg_dirty[9]), 32'd1);
        set_acc(2, 1'b0, 1'b0, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule